// File: doc/BRIEF.md
# Modem Control and Multifunction Output Channel

This block is the per-channel modem-control slice of a serial-port register file. It keeps the control bits that drive the active-low data-terminal-ready output and the general-purpose output used as a programmable pin level. It brings the active-low data-set-ready and ring inputs into the clock domain, and it latches change events for them. When change events are enabled, it raises an active-high interrupt.

A single multifunction pin carries one of three things, chosen by a two-bit select field. It can carry the programmable output level, the 16x baud tick, or an active-low receive-ready flag. The receive-ready flag changes meaning with the DMA mode. Register writes come in as one-cycle strobes that carry a data byte. A read strobe on the status register clears the latched events.

Top module: `uart_modem_ctl`

## Requirements
- R1: A write to the control register with bit 0 at 1 drives `dtr_n` low in the cycle after the write edge. A write with bit 0 at 0 drives it high.
- R2: While `rst` is high, every register is cleared: `dtr_n` = 1, `mf_out` = 1, `irq` = 0, `msr_q` = 0, the interrupt enable is off, and the select field is 00.
- R3: The inputs `dsr_n` and `ri_n` pass through two synchronizing flops. `msr_q[2]` shows DSR active and `msr_q[3]` shows RI active, two edges after a pin change. Any change of the synchronized DSR sets the event `msr_q[0]` on the third edge.
- R4: The ring event `msr_q[1]` is set only when `ri_n` goes from low to high, on the third edge after the pin change. A high-to-low change of `ri_n` sets no event.
- R5: `irq` is high exactly when bit 3 of the last interrupt-enable write is 1 and `msr_q[0]` or `msr_q[1]` is set.
- R6: The select field is bits 2:1 of an alternate-function write. Codes 00 and 11 choose the output-level function, and `mf_out` is then the inverse of control bit 3. `mf_out` is registered, so it reflects its inputs one edge later.
- R7: Select code 01 makes `mf_out` follow `baud16` one edge later.
- R8: Select code 10 with `dma_mode` = 0 makes `mf_out` low exactly when `rx_empty` = 0.
- R9: Select code 10 with `dma_mode` = 1 makes `mf_out` low exactly when `rx_empty` = 0 and `rx_trig` = 1.
- R10: A `rd_msr` strobe clears `msr_q[1:0]` at that edge, unless a new event is detected at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_mcr | input | 1 | Control register write strobe |
| wr_ier | input | 1 | Interrupt enable write strobe |
| wr_afr | input | 1 | Alternate-function write strobe |
| wr_data | input | 8 | Write data byte |
| rd_msr | input | 1 | Status read strobe, clears events |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| baud16 | input | 1 | 16x baud tick |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_trig | input | 1 | Receive FIFO trigger level reached |
| dma_mode | input | 1 | DMA mode select (0 or 1) |
| dtr_n | output | 1 | Data terminal ready, active low |
| mf_out | output | 1 | Multifunction pin |
| irq | output | 1 | Interrupt, active high |
| msr_q | output | 4 | {RI active, DSR active, RI rise event, DSR change event} |

## Verification
A wrong select code or a stale control bit shows on `mf_out` one edge after the inputs settle. The random phase exposes it by sweeping every code against the FIFO flags, the tick and the DMA mode. A wrong synchronizer depth or a wrong edge polarity shows as an event in `msr_q` that arrives one edge early or late, or that follows the wrong direction of the ring pin. It also shows as a missing or unwanted `irq` within three edges of the pin change. A clear that fails to happen leaves `irq` high on the edge right after the read strobe.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int DATA_W      = 8;
    localparam int MCR_DTR_BIT = 0;
    localparam int MCR_OP2_BIT = 3;
    localparam int IER_MSI_BIT = 3;
    localparam int AFR_SEL_LSB = 1;
    localparam int MSR_W       = 4;

    typedef enum logic [1:0] {
        MF_OP2   = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_RSV   = 2'b11
    } mf_sel_e;

    typedef struct packed {
        logic    dtr_on;
        logic    op2_on;
        logic    msi_en;
        mf_sel_e sel;
    } mdm_ctl_t;

    typedef struct packed {
        logic ri_act;
        logic dsr_act;
        logic ri_evt;
        logic dsr_evt;
    } mdm_stat_t;

    // Active-low ready flag: high when nothing usable is in the receive path
    function automatic logic rxrdy_level(input logic empty, input logic trig,
                                         input logic dma);
        return dma ? (empty | ~trig) : empty;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= {W{RST_VAL}};
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_events.sv
module mdm_events (
    input  logic clk,
    input  logic rst,
    input  logic dsr_s,
    input  logic ri_s,
    input  logic clr,
    output logic dsr_evt,
    output logic ri_evt
);
    logic dsr_prev, ri_prev;
    logic dsr_hit, ri_hit;

    assign dsr_hit = dsr_s ^ dsr_prev;
    assign ri_hit  = ri_s & ~ri_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            dsr_prev <= 1'b1;
            ri_prev  <= 1'b1;
            dsr_evt  <= 1'b0;
            ri_evt   <= 1'b0;
        end else begin
            dsr_prev <= dsr_s;
            ri_prev  <= ri_s;
            dsr_evt  <= dsr_hit | (dsr_evt & ~clr);
            ri_evt   <= ri_hit  | (ri_evt  & ~clr);
        end
    end
endmodule

// File: rtl/mdm_mfmux.sv
module mdm_mfmux
    import mdm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mf_sel_e sel,
    input  logic    op2_on,
    input  logic    baud16,
    input  logic    rx_empty,
    input  logic    rx_trig,
    input  logic    dma_mode,
    output logic    mf_out
);
    logic mf_nxt;

    always_comb begin
        unique case (sel)
            MF_BAUD:  mf_nxt = baud16;
            MF_RXRDY: mf_nxt = rxrdy_level(rx_empty, rx_trig, dma_mode);
            default:  mf_nxt = ~op2_on;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mf_out <= 1'b1;
        else     mf_out <= mf_nxt;
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mcr,
    input  logic              wr_ier,
    input  logic              wr_afr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_msr,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              baud16,
    input  logic              rx_empty,
    input  logic              rx_trig,
    input  logic              dma_mode,
    output logic              dtr_n,
    output logic              mf_out,
    output logic              irq,
    output logic [MSR_W-1:0]  msr_q
);
    mdm_ctl_t  ctl_q;
    mdm_stat_t stat;
    logic [1:0] pins_s;
    logic [1:0] sel_q;
    logic       op2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{dtr_on: 1'b0, op2_on: 1'b0, msi_en: 1'b0, sel: MF_OP2};
        end else begin
            if (wr_mcr) begin
                ctl_q.dtr_on <= wr_data[MCR_DTR_BIT];
                ctl_q.op2_on <= wr_data[MCR_OP2_BIT];
            end
            if (wr_ier)
                ctl_q.msi_en <= wr_data[IER_MSI_BIT];
            if (wr_afr)
                ctl_q.sel <= mf_sel_e'(wr_data[AFR_SEL_LSB +: 2]);
        end
    end

    mdm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ri_n, dsr_n}),
        .q   (pins_s)
    );

    mdm_events u_evt (
        .clk     (clk),
        .rst     (rst),
        .dsr_s   (pins_s[0]),
        .ri_s    (pins_s[1]),
        .clr     (rd_msr),
        .dsr_evt (stat.dsr_evt),
        .ri_evt  (stat.ri_evt)
    );

    assign stat.dsr_act = ~pins_s[0];
    assign stat.ri_act  = ~pins_s[1];

    mdm_mfmux u_mf (
        .clk      (clk),
        .rst      (rst),
        .sel      (ctl_q.sel),
        .op2_on   (ctl_q.op2_on),
        .baud16   (baud16),
        .rx_empty (rx_empty),
        .rx_trig  (rx_trig),
        .dma_mode (dma_mode),
        .mf_out   (mf_out)
    );

    assign sel_q = ctl_q.sel;
    assign op2_q = ctl_q.op2_on;
    assign dtr_n = ~ctl_q.dtr_on;
    assign irq   = ctl_q.msi_en & (stat.dsr_evt | stat.ri_evt);
    assign msr_q = stat;
endmodule

// File: rtl/mdm_ctl_chk.sv
module mdm_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_mcr,
    input logic [7:0] wr_data,
    input logic       dtr_n,
    input logic       mf_out,
    input logic       irq,
    input logic [3:0] msr_q,
    input logic [1:0] sel_q,
    input logic       op2_q
);
    AST_DTR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_mcr |=> (dtr_n == ~$past(wr_data[0]))); // R1

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        rst |=> (dtr_n && mf_out && !irq && msr_q == 4'b0)); // R2

    AST_RI_EVENT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(msr_q[1]) |-> !msr_q[3]); // R4

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> (msr_q[1:0] != 2'b00)); // R5

    AST_OP2_PIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(sel_q) == 2'b00 || $past(sel_q) == 2'b11))
        |-> (mf_out == ~$past(op2_q))); // R6
endmodule

bind uart_modem_ctl mdm_ctl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_mcr  (wr_mcr),
    .wr_data (wr_data),
    .dtr_n   (dtr_n),
    .mf_out  (mf_out),
    .irq     (irq),
    .msr_q   (msr_q),
    .sel_q   (sel_q),
    .op2_q   (op2_q)
);

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst, wr_mcr, wr_ier, wr_afr, rd_msr;
    logic [7:0] wr_data;
    logic dsr_n, ri_n, baud16, rx_empty, rx_trig, dma_mode;
    logic dtr_n, mf_out, irq;
    logic [3:0] msr_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [1:0] m_sel;
    logic m_op2;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctl dut (
        .clk(clk), .rst(rst), .wr_mcr(wr_mcr), .wr_ier(wr_ier), .wr_afr(wr_afr),
        .wr_data(wr_data), .rd_msr(rd_msr), .dsr_n(dsr_n), .ri_n(ri_n),
        .baud16(baud16), .rx_empty(rx_empty), .rx_trig(rx_trig), .dma_mode(dma_mode),
        .dtr_n(dtr_n), .mf_out(mf_out), .irq(irq), .msr_q(msr_q)
    );

    function automatic logic exp_mf(input logic [1:0] sel, input logic op2,
                                    input logic bd, input logic emp,
                                    input logic trg, input logic dma);
        case (sel)
            2'b01:   return bd;
            2'b10:   return dma ? (emp | ~trg) : emp;
            default: return ~op2;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        if (which == 0) wr_mcr = 1'b1;
        if (which == 1) wr_ier = 1'b1;
        if (which == 2) wr_afr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_mcr = 1'b0; wr_ier = 1'b0; wr_afr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1; wr_mcr = 0; wr_ier = 0; wr_afr = 0; rd_msr = 0; wr_data = 0;
        dsr_n = 1; ri_n = 1; baud16 = 0; rx_empty = 1; rx_trig = 0; dma_mode = 0;
        edges(3);
        // R2: reset state
        check("R2 dtr_n", dtr_n, 1); check("R2 mf_out", mf_out, 1);
        check("R2 irq", irq, 0); check("R2 msr", msr_q, 0);
        rst = 0;
        edges(1);

        // R1: DTR control
        wr(0, 8'h01); check("R1 dtr low", dtr_n, 0);
        wr(0, 8'h00); check("R1 dtr high", dtr_n, 1);

        // R6: OP2 mode, also the reserved code
        wr(0, 8'h08); edges(1); check("R6 op2 low", mf_out, 0);
        wr(2, 8'h06); edges(1); check("R6 code11 low", mf_out, 0);
        wr(0, 8'h00); edges(1); check("R6 code11 high", mf_out, 1);

        // R7: baud tick
        wr(2, 8'h02); baud16 = 1; edges(1); check("R7 tick hi", mf_out, 1);
        baud16 = 0; edges(1); check("R7 tick lo", mf_out, 0);

        // R8 / R9: receive ready
        wr(2, 8'h04); dma_mode = 0; rx_empty = 0; rx_trig = 0;
        edges(1); check("R8 data present", mf_out, 0);
        dma_mode = 1; edges(1); check("R9 below trigger", mf_out, 1);
        rx_trig = 1; edges(1); check("R9 trigger", mf_out, 0);
        rx_empty = 1; edges(1); check("R9 empty", mf_out, 1);

        // R3: DSR change event, latency
        dsr_n = 0; edges(2);
        check("R3 level at 2", msr_q[2], 1); check("R3 no evt at 2", msr_q[0], 0);
        edges(1); check("R3 evt at 3", msr_q[0], 1);
        check("R5 irq disabled", irq, 0);
        wr(1, 8'h08); check("R5 irq enabled", irq, 1);

        // R10: read clears
        rd_msr = 1; edges(1); rd_msr = 0;
        check("R10 cleared", msr_q[1:0], 0); check("R10 irq low", irq, 0);

        // R4: ring falling edge sets nothing, rising edge sets event
        ri_n = 0; edges(3);
        check("R4 ri level", msr_q[3], 1); check("R4 no evt on fall", msr_q[1], 0);
        ri_n = 1; edges(2); check("R4 no evt at 2", msr_q[1], 0);
        edges(1); check("R4 evt on rise", msr_q[1], 1); check("R5 irq ri", irq, 1);
        wr(1, 8'h00); check("R5 irq masked", irq, 0);

        // Random sweep of the multifunction pin (R6 R7 R8 R9)
        m_op2 = 0; m_sel = 2'b10;
        for (int k = 0; k < 300; k++) begin
            if (($urandom % 8) == 0) begin
                m_sel = 2'($urandom); wr(2, {5'b0, m_sel, 1'b0});
            end
            if (($urandom % 8) == 0) begin
                m_op2 = 1'($urandom); wr(0, {4'b0, m_op2, 3'b0});
            end
            baud16 = 1'($urandom); rx_empty = 1'($urandom);
            rx_trig = 1'($urandom); dma_mode = 1'($urandom);
            edges(1);
            check("R6-R9 random mf", mf_out,
                  exp_mf(m_sel, m_op2, baud16, rx_empty, rx_trig, dma_mode));
        end
        finish_run();
    end
endmodule